// File: doc/BRIEF.md
# Separate-Port Double-Rate Burst-of-Four SRAM

This block is a synthesizable static memory with independent write and read ports. Every access is a burst of four data beats, two per clock period: the beat of the rising half of a period travels on a `*_rise` lane and the beat of the falling half on a matching `*_fall` lane. The write port collects the four beats of a burst, each with its own per-lane byte enables, into one word four beats wide. It then stores that word into the internal array in a single update. The read port fetches one wide word per burst and steps it out two beats per period, with a valid strobe.

Each address names one four-beat word, so the address is two bits narrower than a beat-granular address would be. The read latency is chosen by a mode input: one period or two. The two pipelines are coherent. A read that is accepted while a write burst is still completing returns the freshly written bytes.

Top module: `qdrb4_sram`

## Requirements
- R1: After reset `rq_valid` is low and both read lanes are zero.
- R2: A write command (`wr_n` low) in period t takes beat 0 on `wd_rise` and beat 1 on `wd_fall` in period t, and beats 2 and 3 on the same lanes in period t+1. All four beats are stored at the one address `wr_addr` and are read back in beat order 0, 1, 2, 3.
- R3: Each beat has its own byte enables on `wbe_rise`/`wbe_fall`. Bit k covers data bits [k*LANE_W +: LANE_W], and a 1 means write. A byte whose enable is 0 keeps its previous content.
- R4: A write command in the period right after an accepted write command is ignored. That period's data is taken as beats 2 and 3 of the earlier burst.
- R5: With `lat2` = 0, a read accepted in period t drives beats 0/1 on `rq_rise`/`rq_fall` in period t+1 and beats 2/3 in period t+2, with `rq_valid` high in both periods.
- R6: With `lat2` = 1, the same beats appear one period later: in periods t+2 and t+3.
- R7: A read command in the period right after an accepted read command is ignored.
- R8: Reads accepted every second period give an unbroken stream of valid beats with no stall, at either latency.
- R9: A read accepted in period t+1 to the address of a write accepted in period t returns the new data for every enabled byte of all four beats, and the old data for the others.
- R10: A read and a write accepted in the same period to the same address return the data from before that write.
- R11: `rq_valid` is high only in periods that carry read beats. When it is low, both read lanes are zero.
- R12: The read and write ports work independently, and commands to different addresses may be accepted on both ports in the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period carries two beats |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| lat2 | input | 1 | Read latency mode: 0 = one period, 1 = two periods |
| rd_n | input | 1 | Active-low read command |
| rd_addr | input | ADDR_W | Read word address |
| wr_n | input | 1 | Active-low write command |
| wr_addr | input | ADDR_W | Write word address |
| wd_rise | input | DATA_W | Write beat of the rising half (beat 0, then 2) |
| wd_fall | input | DATA_W | Write beat of the falling half (beat 1, then 3) |
| wbe_rise | input | DATA_W/LANE_W | Byte enables of the rising-half write beat |
| wbe_fall | input | DATA_W/LANE_W | Byte enables of the falling-half write beat |
| rq_rise | output | DATA_W | Read beat of the rising half (beat 0, then 2) |
| rq_fall | output | DATA_W | Read beat of the falling half (beat 1, then 3) |
| rq_valid | output | 1 | High in each period that carries read beats |

## Verification
The assertions check the timing on every cycle. They confirm that each accepted read raises `rq_valid` for exactly the two periods its latency mode calls for, that no valid period appears without a read behind it, and that both lanes stay at zero while idle. Only the bench's scenarios can show the data itself. That covers beat order, per-beat byte masking, the ignored second commands, and the coherence cases: a read one period after a write, and a read in the same period as a write. The bench covers these cases under both latency settings and in mixed random traffic on a few addresses.

// File: rtl/qdrb4_pkg.sv
package qdrb4_pkg;
   localparam int BURST_LEN    = 4;
   localparam int BEATS_PER_CK = 2;
   typedef enum logic {
      RD_LAT_ONE = 1'b0,
      RD_LAT_TWO = 1'b1
   } rd_lat_e;
endpackage

// File: rtl/qdrb4_wr_gather.sv
// Write demultiplexer: holds the first two beats of a burst and presents
// the full four-beat word, with all masks, in the burst's second period.
module qdrb4_wr_gather #(
   parameter int DATA_W = 18,
   parameter int NLANE  = 2,
   parameter int ADDR_W = 6
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     wr_n,
   input  logic [ADDR_W-1:0]                        wr_addr,
   input  logic [DATA_W-1:0]                        d_rise,
   input  logic [DATA_W-1:0]                        d_fall,
   input  logic [NLANE-1:0]                         be_rise,
   input  logic [NLANE-1:0]                         be_fall,
   output logic                                     commit_o,
   output logic [ADDR_W-1:0]                        commit_addr_o,
   output logic [qdrb4_pkg::BURST_LEN*DATA_W-1:0]   commit_data_o,
   output logic [qdrb4_pkg::BURST_LEN*NLANE-1:0]    commit_mask_o
);
   localparam int HEAD_D = qdrb4_pkg::BEATS_PER_CK * DATA_W;
   localparam int HEAD_M = qdrb4_pkg::BEATS_PER_CK * NLANE;

   logic              second_q;
   logic [ADDR_W-1:0] addr_q;
   logic [HEAD_D-1:0] head_d_q;
   logic [HEAD_M-1:0] head_m_q;
   logic              accept;

   assign accept = !wr_n && !second_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) second_q <= 1'b0;
      else        second_q <= accept;
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         addr_q   <= wr_addr;
         head_d_q <= {d_fall, d_rise};
         head_m_q <= {be_fall, be_rise};
      end
   end

   assign commit_o      = second_q;
   assign commit_addr_o = addr_q;
   assign commit_data_o = {d_fall, d_rise, head_d_q};
   assign commit_mask_o = {be_fall, be_rise, head_m_q};
endmodule

// File: rtl/qdrb4_array.sv
// Wide storage: one four-beat word per address, byte-masked update,
// read port that forwards a same-period update byte by byte.
module qdrb4_array #(
   parameter int DATA_W = 18,
   parameter int NLANE  = 2,
   parameter int ADDR_W = 6
) (
   input  logic                                   clk,
   input  logic                                   wr_en,
   input  logic [ADDR_W-1:0]                      wr_addr,
   input  logic [qdrb4_pkg::BURST_LEN*DATA_W-1:0] wr_word,
   input  logic [qdrb4_pkg::BURST_LEN*NLANE-1:0]  wr_mask,
   input  logic [ADDR_W-1:0]                      rd_addr,
   output logic [qdrb4_pkg::BURST_LEN*DATA_W-1:0] rd_word
);
   localparam int LANE_W = DATA_W / NLANE;
   localparam int SLOTS  = qdrb4_pkg::BURST_LEN * NLANE;
   localparam int WORD_W = qdrb4_pkg::BURST_LEN * DATA_W;
   localparam int DEPTH  = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] raw;
   logic              hit;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int s = 0; s < SLOTS; s++) begin
            if (wr_mask[s]) mem[wr_addr][s*LANE_W +: LANE_W] <= wr_word[s*LANE_W +: LANE_W];
         end
      end
   end

   assign raw = mem[rd_addr];
   assign hit = wr_en && (wr_addr == rd_addr);

   for (genvar s = 0; s < SLOTS; s++) begin : g_fwd
      assign rd_word[s*LANE_W +: LANE_W] = (hit && wr_mask[s]) ? wr_word[s*LANE_W +: LANE_W]
                                                               : raw[s*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/qdrb4_rd_serial.sv
// Read output path: optional extra stage for the longer latency, then a
// two-phase multiplexer stepping the wide word out two beats per period.
module qdrb4_rd_serial #(
   parameter int DATA_W = 18
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   lat2,
   input  logic                                   load,
   input  logic [qdrb4_pkg::BURST_LEN*DATA_W-1:0] word_in,
   output logic [DATA_W-1:0]                      q_rise,
   output logic [DATA_W-1:0]                      q_fall,
   output logic                                   q_valid
);
   import qdrb4_pkg::*;
   localparam int WORD_W = BURST_LEN * DATA_W;

   rd_lat_e           mode;
   logic              st_v;
   logic [WORD_W-1:0] st_w;
   logic              ser_v;
   logic              ser_ph;
   logic [WORD_W-1:0] ser_w;
   logic              start;
   logic [WORD_W-1:0] start_w;

   assign mode    = rd_lat_e'(lat2);
   assign start   = (mode == RD_LAT_TWO) ? st_v : load;
   assign start_w = (mode == RD_LAT_TWO) ? st_w : word_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_v   <= 1'b0;
         ser_v  <= 1'b0;
         ser_ph <= 1'b0;
      end else begin
         st_v <= load && (mode == RD_LAT_TWO);
         if (start) begin
            ser_v  <= 1'b1;
            ser_ph <= 1'b0;
         end else if (ser_v && !ser_ph) begin
            ser_ph <= 1'b1;
         end else begin
            ser_v  <= 1'b0;
            ser_ph <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (load)  st_w  <= word_in;
      if (start) ser_w <= start_w;
   end

   assign q_rise  = !ser_v ? '0 : (ser_ph ? ser_w[2*DATA_W +: DATA_W] : ser_w[0 +: DATA_W]);
   assign q_fall  = !ser_v ? '0 : (ser_ph ? ser_w[3*DATA_W +: DATA_W] : ser_w[DATA_W +: DATA_W]);
   assign q_valid = ser_v;
endmodule

// File: rtl/qdrb4_sram.sv
module qdrb4_sram #(
   parameter int DATA_W = 18,
   parameter int LANE_W = 9,
   parameter int ADDR_W = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lat2,
   input  logic                       rd_n,
   input  logic [ADDR_W-1:0]          rd_addr,
   input  logic                       wr_n,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wd_rise,
   input  logic [DATA_W-1:0]          wd_fall,
   input  logic [DATA_W/LANE_W-1:0]   wbe_rise,
   input  logic [DATA_W/LANE_W-1:0]   wbe_fall,
   output logic [DATA_W-1:0]          rq_rise,
   output logic [DATA_W-1:0]          rq_fall,
   output logic                       rq_valid
);
   localparam int NLANE  = DATA_W / LANE_W;
   localparam int WORD_W = qdrb4_pkg::BURST_LEN * DATA_W;
   localparam int MASK_W = qdrb4_pkg::BURST_LEN * NLANE;

   if (LANE_W < 1 || DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("qdrb4_sram: DATA_W must be a whole number of lanes");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("qdrb4_sram: ADDR_W out of range 1..12");
   end

   logic              rd_busy;
   logic              rd_accept;
   logic              cm_en;
   logic [ADDR_W-1:0] cm_addr;
   logic [WORD_W-1:0] cm_word;
   logic [MASK_W-1:0] cm_mask;
   logic [WORD_W-1:0] fetch_word;

   assign rd_accept = !rd_n && !rd_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_busy <= 1'b0;
      else        rd_busy <= rd_accept;
   end

   qdrb4_wr_gather #(.DATA_W(DATA_W), .NLANE(NLANE), .ADDR_W(ADDR_W)) u_gather (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_addr(wr_addr),
      .d_rise(wd_rise), .d_fall(wd_fall), .be_rise(wbe_rise), .be_fall(wbe_fall),
      .commit_o(cm_en), .commit_addr_o(cm_addr), .commit_data_o(cm_word), .commit_mask_o(cm_mask)
   );

   qdrb4_array #(.DATA_W(DATA_W), .NLANE(NLANE), .ADDR_W(ADDR_W)) u_array (
      .clk(clk), .wr_en(cm_en), .wr_addr(cm_addr), .wr_word(cm_word), .wr_mask(cm_mask),
      .rd_addr(rd_addr), .rd_word(fetch_word)
   );

   qdrb4_rd_serial #(.DATA_W(DATA_W)) u_serial (
      .clk(clk), .rst_n(rst_n), .lat2(lat2), .load(rd_accept), .word_in(fetch_word),
      .q_rise(rq_rise), .q_fall(rq_fall), .q_valid(rq_valid)
   );
endmodule

// File: rtl/qdrb4_sram_chk.sv
module qdrb4_sram_chk #(
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lat2,
   input logic              rd_n,
   input logic [DATA_W-1:0] rq_rise,
   input logic [DATA_W-1:0] rq_fall,
   input logic              rq_valid
);
   logic busy_q, acc, acc_d1, acc_d2, acc_d3;

   assign acc = !rd_n && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; acc_d1 <= 1'b0; acc_d2 <= 1'b0; acc_d3 <= 1'b0;
      end else begin
         busy_q <= acc; acc_d1 <= acc; acc_d2 <= acc_d1; acc_d3 <= acc_d2;
      end
   end

   assert_lat1_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !lat2) |=> rq_valid);
   assert_lat1_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_d1 && !lat2) |=> rq_valid);
   assert_lat2_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_d1 && lat2) |=> rq_valid);
   assert_lat2_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_d2 && lat2) |=> rq_valid);
   assert_valid_has_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid |-> (lat2 ? (acc_d2 || acc_d3) : (acc_d1 || acc_d2)));
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rq_valid |-> (rq_rise == '0 && rq_fall == '0));
endmodule

bind qdrb4_sram qdrb4_sram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lat2(lat2), .rd_n(rd_n),
   .rq_rise(rq_rise), .rq_fall(rq_fall), .rq_valid(rq_valid)
);

// File: tb/qdrb4_sram_test.sv
`timescale 1ns/1ps
module qdrb4_sram_test;
   localparam int DW    = 18;
   localparam int LW    = 9;
   localparam int AW    = 6;
   localparam int NL    = DW / LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lat2 = 1'b0;
   logic          rd_n = 1'b1, wr_n = 1'b1;
   logic [AW-1:0] rd_addr = '0, wr_addr = '0;
   logic [DW-1:0] wd_rise = '0, wd_fall = '0;
   logic [NL-1:0] wbe_rise = '0, wbe_fall = '0;
   logic [DW-1:0] rq_rise, rq_fall;
   logic          rq_valid;

   always #2.5 clk = ~clk;

   qdrb4_sram #(.DATA_W(DW), .LANE_W(LW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .lat2(lat2), .rd_n(rd_n), .rd_addr(rd_addr),
      .wr_n(wr_n), .wr_addr(wr_addr), .wd_rise(wd_rise), .wd_fall(wd_fall),
      .wbe_rise(wbe_rise), .wbe_fall(wbe_fall),
      .rq_rise(rq_rise), .rq_fall(rq_fall), .rq_valid(rq_valid)
   );

   int checks = 0, fails = 0, cyc = 0;
   string tag = "R1";

   logic [DW-1:0] rmem [DEPTH][4];
   bit            pend = 0, rbusy = 0;
   int            pend_a = 0;
   logic [DW-1:0] pd [4];
   logic [NL-1:0] pm [4];
   logic [DW-1:0] er [int];
   logic [DW-1:0] ef [int];

   localparam logic [NL-1:0] FULL = '1;

   function automatic logic [DW-1:0] pat(input int s, input int b);
      return DW'(s * 613 + b * 97 + 41) ^ DW'(b << 13);
   endfunction

   task automatic check_out();
      logic          ev;
      logic [DW-1:0] xr, xf;
      ev = er.exists(cyc);
      xr = ev ? er[cyc] : '0;
      xf = ev ? ef[cyc] : '0;
      if (ev) begin er.delete(cyc); ef.delete(cyc); end
      checks++;
      if (rq_valid !== ev || rq_rise !== xr || rq_fall !== xf) begin
         fails++;
         $display("FAIL %s cycle %0d: valid=%b rise=%h fall=%h expected valid=%b rise=%h fall=%h",
                  tag, cyc, rq_valid, rq_rise, rq_fall, ev, xr, xf);
      end
   endtask

   task automatic step(input bit rdn, input int ra, input bit wrn, input int wa,
                       input logic [DW-1:0] dr, input logic [DW-1:0] df,
                       input logic [NL-1:0] mr, input logic [NL-1:0] mf);
      int lat;
      @(negedge clk);
      check_out();
      rd_n = rdn; rd_addr = AW'(ra); wr_n = wrn; wr_addr = AW'(wa);
      wd_rise = dr; wd_fall = df; wbe_rise = mr; wbe_fall = mf;
      if (pend) begin
         pd[2] = dr; pd[3] = df; pm[2] = mr; pm[3] = mf;
         for (int b = 0; b < 4; b++)
            for (int k = 0; k < NL; k++)
               if (pm[b][k]) rmem[pend_a][b][k*LW +: LW] = pd[b][k*LW +: LW];
         pend = 0;
      end else if (!wrn) begin
         pend = 1; pend_a = wa % DEPTH;
         pd[0] = dr; pd[1] = df; pm[0] = mr; pm[1] = mf;
      end
      if (!rdn && !rbusy) begin
         rbusy = 1;
         lat = lat2 ? 2 : 1;
         er[cyc+lat]   = rmem[ra % DEPTH][0]; ef[cyc+lat]   = rmem[ra % DEPTH][1];
         er[cyc+lat+1] = rmem[ra % DEPTH][2]; ef[cyc+lat+1] = rmem[ra % DEPTH][3];
      end else begin
         rbusy = 0;
      end
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1, 0, 1, 0, '0, '0, '0, '0);
   endtask

   task automatic wr(input int a, input int s, input logic [NL-1:0] m0, input logic [NL-1:0] m1,
                     input logic [NL-1:0] m2, input logic [NL-1:0] m3);
      step(1, 0, 0, a, pat(s, 0), pat(s, 1), m0, m1);
      step(1, 0, 1, 0, pat(s, 2), pat(s, 3), m2, m3);
   endtask

   task automatic rd(input int a);
      step(0, a, 1, 0, '0, '0, '0, '0);
      step(1, 0, 1, 0, '0, '0, '0, '0);
   endtask

   task automatic directed();
      tag = "R5";
      if (lat2) tag = "R6";
      rd(3); idle(3); rd(60); idle(4);
      tag = "R8";
      for (int i = 0; i < 6; i++) rd(i * 7 % DEPTH);
      idle(4);
      tag = "R7";
      step(0, 10, 1, 0, '0, '0, '0, '0); step(0, 11, 1, 0, '0, '0, '0, '0); idle(4);
      tag = "R3";
      wr(20, 900, 2'b01, 2'b10, 2'b00, 2'b11); rd(20); idle(4);
      tag = "R9";
      step(1, 0, 0, 21, pat(901, 0), pat(901, 1), 2'b11, 2'b01);
      step(0, 21, 1, 0, pat(901, 2), pat(901, 3), 2'b10, 2'b11);
      idle(4);
      tag = "R10";
      step(0, 22, 0, 22, pat(902, 0), pat(902, 1), FULL, FULL);
      step(1, 0, 1, 0, pat(902, 2), pat(902, 3), FULL, FULL);
      idle(2); rd(22); idle(4);
      tag = "R4";
      step(1, 0, 0, 23, pat(903, 0), pat(903, 1), FULL, FULL);
      step(1, 0, 0, 24, pat(903, 2), pat(903, 3), FULL, FULL);
      idle(2); rd(24); rd(23); idle(4);
      tag = "R12";
      for (int i = 0; i < 8; i++) begin
         step(0, 30 + i, 0, 40 + i, pat(950 + i, 0), pat(950 + i, 1), FULL, 2'b10);
         step(1, 0, 1, 0, pat(950 + i, 2), pat(950 + i, 3), 2'b01, FULL);
      end
      idle(2);
      for (int i = 0; i < 8; i++) rd(40 + i);
      tag = "R11";
      idle(6);
   endtask

   task automatic random_mix(input int n);
      tag = "R12";
      for (int i = 0; i < n; i++)
         step(($urandom % 3) == 0 ? 1'b0 : 1'b1, $urandom % 4,
              ($urandom % 2) == 0 ? 1'b0 : 1'b1, $urandom % 4,
              DW'($urandom), DW'($urandom), NL'($urandom), NL'($urandom));
      tag = "R11";
      idle(6);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (rq_valid !== 1'b0 || rq_rise !== '0 || rq_fall !== '0) begin
         fails++;
         $display("FAIL R1 reset: valid=%b rise=%h fall=%h expected valid=0 rise=0 fall=0",
                  rq_valid, rq_rise, rq_fall);
      end
      tag = "R2";
      for (int a = 0; a < DEPTH; a++) wr(a, a, FULL, FULL, FULL, FULL);
      idle(2);
      for (int a = 0; a < 8; a++) rd(a);
      idle(4);
      directed();
      random_mix(1500);
      lat2 = 1'b1;
      idle(2);
      tag = "R6";
      for (int a = 0; a < 8; a++) rd(a + 50);
      idle(4);
      directed();
      random_mix(1500);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule